// File: doc/BRIEF.md
# Receive Idle-Insertion Jitter Buffer

This block sits in a receive PCS after the FEC parity has been removed. Its input is a stream of decoded 9-bit characters with a valid strobe. The strobe drops during the slots where a parity region was deleted, and a one-cycle marker flags each deleted region. Its output is an unbroken character stream at one character per clock. Every accepted character, inter-frame IDLEs included, passes through one FIFO, and nothing bypasses it.

While a frame is open, a write-side state machine counts the deleted parity regions. The machine has two states. `W_GAP` moves to `W_FRAME` on a START character. `W_FRAME` returns to `W_GAP` on a TERMINATE character, and a START seen in `W_FRAME` restarts the count. The count travels through the FIFO attached to the TERMINATE entry. A parity marker that arrives while no frame is open is credited at once to the pending-IDLE count.

The read-side state machine also has two states. It stays in `R_FILL` until the FIFO holds the pre-fill depth, then moves to `R_RUN` and stays there until reset. In `R_RUN` it takes one of three actions each cycle. INSERT is chosen when IDLEs are pending and the previous output was TERMINATE or IDLE. POP is chosen when the FIFO is not empty. STARVE is chosen otherwise. A popped TERMINATE adds four IDLEs per counted region to the pending count. Every frame therefore leaves after the same fixed delay, and the replacement IDLEs follow its end.

Top module: `rx_idle_ins_buf`

## Requirements
- R1: While the synchronous reset is high and on the cycle after it, `out_char` is IDLE (0x107), `out_run` is 0, both sticky flags are 0 and the FIFO is empty.
- R2: `out_run` is 0 and `out_char` is IDLE until PREFILL (regions × blocks per region, default 32) characters have been written. `out_run` rises on the following clock and then stays high.
- R3: Characters are 9 bits {control flag, byte}: IDLE = 0x107, START = 0x1FB, TERMINATE = 0x1FD, and data has the control flag at 0. In `R_RUN` every accepted character, inter-frame IDLEs included, leaves in arrival order, one output per clock.
- R4: Each parity marker seen while a frame is open is counted. When that frame's TERMINATE is output, 4 × count inserted IDLEs follow it, ahead of any later FIFO character. A frame with no markers gets no inserted IDLEs.
- R5: An inserted IDLE is emitted only when the previous output was TERMINATE or IDLE, so no IDLE appears between a START and its TERMINATE.
- R6: A parity marker seen while no frame is open adds 4 IDLEs to the pending count at once. Long idle stretches full of deleted regions therefore cause neither underflow nor overflow.
- R7: The delay from a START being written to that START being output is the same for every frame, whatever its length, its number of deleted regions or where those regions fall.
- R8: A write when the FIFO already holds FIFO_DEPTH (2 × PREFILL) entries is dropped and sets `ovf_flag`, which stays high until reset.
- R9: In `R_RUN`, when no insertion is allowed and the FIFO is empty, the output is IDLE and `unf_flag` sets and stays high until reset.
- R10: The per-frame region count saturates at the region limit (default 8), so a frame with more markers gets exactly 32 inserted IDLEs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one character per cycle |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input character valid, low during deleted parity slots |
| in_char | input | 9 | Input character {control flag, byte} |
| in_par_mark | input | 1 | One-cycle pulse per deleted parity region |
| out_char | output | 9 | Output character stream |
| out_run | output | 1 | High once the pre-fill is complete |
| ovf_flag | output | 1 | Sticky FIFO overflow |
| unf_flag | output | 1 | Sticky FIFO underflow |

## Verification
The hardest state to reach from the ports is a FIFO at its full physical depth. A well-formed stream never gets there, because every deleted region both withholds a write and later withholds a read. The stimulus reaches it by raising the parity marker while the valid strobe stays high, first inside a frame to drive the region count past its limit and then across a long idle stretch. That piles up pending IDLEs which stall reads while writes continue. Constant latency is checked separately by timing each START from entry to exit across frames with zero to eight regions placed at different points.

// File: rtl/iib_pkg.sv
package iib_pkg;
    localparam int CHAR_W = 9;
    typedef logic [CHAR_W-1:0] char_t;

    localparam char_t CH_IDLE  = 9'h107;
    localparam char_t CH_START = 9'h1FB;
    localparam char_t CH_TERM  = 9'h1FD;

    typedef enum logic { W_GAP, W_FRAME } wr_state_e;
    typedef enum logic { R_FILL, R_RUN } rd_state_e;
    typedef enum logic [1:0] { ACT_HOLD, ACT_INSERT, ACT_POP, ACT_STARVE } rd_act_e;

    function automatic logic ends_run(input char_t c);
        return (c == CH_IDLE) || (c == CH_TERM);
    endfunction
endpackage

// File: rtl/iib_fifo.sv
module iib_fifo #(
    parameter int DATA_W = 13,
    parameter int DEPTH  = 64,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    output logic [OCC_W-1:0]  occ
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (push) begin
                wr_ptr <= ptr_inc(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= ptr_inc(rd_ptr);
            end
            occ <= occ + OCC_W'(push) - OCC_W'(pop);
        end
    end

    assign pop_data = mem[rd_ptr];
endmodule

// File: rtl/iib_wr_track.sv
module iib_wr_track
    import iib_pkg::*;
#(
    parameter int MAX_REGIONS = 8,
    parameter int FIFO_DEPTH  = 64,
    parameter int CNT_W       = 4,
    parameter int OCC_W       = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  char_t            in_char,
    input  logic             in_mark,
    input  logic [OCC_W-1:0] occ,
    output logic             push,
    output logic [CNT_W-1:0] push_cnt,
    output logic             between_mark,
    output logic             ovf_flag,
    output logic [CNT_W-1:0] frame_cnt
);
    wr_state_e        state;
    wr_state_e        state_nxt;
    logic             full;
    logic             frame_mark;
    logic             opens;
    logic             closes;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] cnt_nxt;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= W_GAP;
        end else begin
            state <= state_nxt;
        end
    end

    // next state and outputs
    always_comb begin
        full         = (occ >= OCC_W'(FIFO_DEPTH));
        frame_mark   = in_mark && (state == W_FRAME);
        between_mark = in_mark && (state == W_GAP);
        opens        = in_valid && (in_char == CH_START);
        closes       = in_valid && (in_char == CH_TERM) && (state == W_FRAME);

        if (frame_mark && (frame_cnt != CNT_W'(MAX_REGIONS))) begin
            cnt_inc = frame_cnt + CNT_W'(1);
        end else begin
            cnt_inc = frame_cnt;
        end

        state_nxt = state;
        cnt_nxt   = cnt_inc;
        unique case (state)
            W_GAP: begin
                if (opens) begin
                    state_nxt = W_FRAME;
                    cnt_nxt   = '0;
                end
            end
            W_FRAME: begin
                if (opens) begin
                    cnt_nxt = '0;
                end else if (closes) begin
                    state_nxt = W_GAP;
                    cnt_nxt   = '0;
                end
            end
            default: state_nxt = W_GAP;
        endcase

        push     = in_valid && !full;
        push_cnt = closes ? cnt_inc : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_cnt <= '0;
            ovf_flag  <= 1'b0;
        end else begin
            frame_cnt <= cnt_nxt;
            if (in_valid && full) begin
                ovf_flag <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/iib_rd_ctrl.sv
module iib_rd_ctrl
    import iib_pkg::*;
#(
    parameter int PREFILL           = 32,
    parameter int BLOCKS_PER_REGION = 4,
    parameter int CNT_W             = 4,
    parameter int PEND_W            = 8,
    parameter int OCC_W             = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OCC_W-1:0] occ,
    input  char_t            pop_char,
    input  logic [CNT_W-1:0] pop_cnt,
    input  logic             between_mark,
    output logic             pop,
    output char_t            out_char,
    output logic             out_run,
    output logic             unf_flag
);
    localparam int SUM_W    = PEND_W + 2;
    localparam int PEND_MAX = (1 << PEND_W) - 1;

    rd_state_e         state;
    rd_state_e         state_nxt;
    rd_act_e           act;
    logic [PEND_W-1:0] pending;
    logic [PEND_W-1:0] pend_nxt;
    logic [SUM_W-1:0]  pend_sum;
    logic [SUM_W-1:0]  add_pop;
    logic [SUM_W-1:0]  add_mark;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= R_FILL;
        end else begin
            state <= state_nxt;
        end
    end

    // action select and next state
    always_comb begin
        state_nxt = state;
        act       = ACT_HOLD;
        unique case (state)
            R_FILL: begin
                if (occ >= OCC_W'(PREFILL)) begin
                    state_nxt = R_RUN;
                end
            end
            R_RUN: begin
                if ((pending != '0) && ends_run(out_char)) begin
                    act = ACT_INSERT;
                end else if (occ != '0) begin
                    act = ACT_POP;
                end else begin
                    act = ACT_STARVE;
                end
            end
            default: state_nxt = R_FILL;
        endcase

        pop      = (act == ACT_POP);
        add_pop  = pop ? SUM_W'(pop_cnt) * SUM_W'(BLOCKS_PER_REGION) : '0;
        add_mark = between_mark ? SUM_W'(BLOCKS_PER_REGION) : '0;
        pend_sum = SUM_W'(pending) - SUM_W'(act == ACT_INSERT) + add_pop + add_mark;
        pend_nxt = (pend_sum > SUM_W'(PEND_MAX)) ? PEND_W'(PEND_MAX) : pend_sum[PEND_W-1:0];
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            out_char <= CH_IDLE;
            pending  <= '0;
            unf_flag <= 1'b0;
        end else begin
            out_char <= pop ? pop_char : CH_IDLE;
            pending  <= pend_nxt;
            if (act == ACT_STARVE) begin
                unf_flag <= 1'b1;
            end
        end
    end

    assign out_run = (state == R_RUN);
endmodule

// File: rtl/rx_idle_ins_buf.sv
module rx_idle_ins_buf
    import iib_pkg::*;
#(
    parameter int REGIONS_PER_FRAME = 8,
    parameter int BLOCKS_PER_REGION = 4,
    parameter int PEND_W            = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [CHAR_W-1:0] in_char,
    input  logic              in_par_mark,
    output logic [CHAR_W-1:0] out_char,
    output logic              out_run,
    output logic              ovf_flag,
    output logic              unf_flag
);
    localparam int PREFILL    = REGIONS_PER_FRAME * BLOCKS_PER_REGION;
    localparam int FIFO_DEPTH = 2 * PREFILL;
    localparam int CNT_W      = $clog2(REGIONS_PER_FRAME + 1);
    localparam int OCC_W      = $clog2(FIFO_DEPTH + 1);
    localparam int ENTRY_W    = CHAR_W + CNT_W;

    logic               push;
    logic               pop;
    logic [CNT_W-1:0]   push_cnt;
    logic [CNT_W-1:0]   frame_cnt;
    logic               between_mark;
    logic [OCC_W-1:0]   fifo_occ;
    logic [ENTRY_W-1:0] pop_entry;
    char_t              pop_char;
    logic [CNT_W-1:0]   pop_cnt;

    iib_wr_track #(
        .MAX_REGIONS (REGIONS_PER_FRAME),
        .FIFO_DEPTH  (FIFO_DEPTH),
        .CNT_W       (CNT_W),
        .OCC_W       (OCC_W)
    ) u_wr (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_char      (in_char),
        .in_mark      (in_par_mark),
        .occ          (fifo_occ),
        .push         (push),
        .push_cnt     (push_cnt),
        .between_mark (between_mark),
        .ovf_flag     (ovf_flag),
        .frame_cnt    (frame_cnt)
    );

    iib_fifo #(
        .DATA_W (ENTRY_W),
        .DEPTH  (FIFO_DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_data ({in_char, push_cnt}),
        .pop       (pop),
        .pop_data  (pop_entry),
        .occ       (fifo_occ)
    );

    assign pop_char = pop_entry[ENTRY_W-1:CNT_W];
    assign pop_cnt  = pop_entry[CNT_W-1:0];

    iib_rd_ctrl #(
        .PREFILL           (PREFILL),
        .BLOCKS_PER_REGION (BLOCKS_PER_REGION),
        .CNT_W             (CNT_W),
        .PEND_W            (PEND_W),
        .OCC_W             (OCC_W)
    ) u_rd (
        .clk          (clk),
        .rst          (rst),
        .occ          (fifo_occ),
        .pop_char     (pop_char),
        .pop_cnt      (pop_cnt),
        .between_mark (between_mark),
        .pop          (pop),
        .out_char     (out_char),
        .out_run      (out_run),
        .unf_flag     (unf_flag)
    );
endmodule

// File: rtl/iib_checker.sv
module iib_checker
    import iib_pkg::*;
#(
    parameter int FIFO_DEPTH  = 64,
    parameter int MAX_REGIONS = 8,
    parameter int OCC_W       = 7,
    parameter int CNT_W       = 4
) (
    input logic             clk,
    input logic             rst,
    input char_t            out_char,
    input logic             out_run,
    input logic             ovf,
    input logic             unf,
    input logic [OCC_W-1:0] occ,
    input logic [CNT_W-1:0] frame_cnt
);
    logic in_frame_out;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame_out <= 1'b0;
        end else if (out_char == CH_START) begin
            in_frame_out <= 1'b1;
        end else if (out_char == CH_TERM) begin
            in_frame_out <= 1'b0;
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> (out_char == CH_IDLE && !out_run && !ovf && !unf && occ == '0)); // R1
    AST_FILL_IDLE: assert property (@(posedge clk) disable iff (rst) !out_run |-> out_char == CH_IDLE); // R2
    AST_RUN_HOLD: assert property (@(posedge clk) disable iff (rst) out_run |=> out_run); // R2
    AST_NO_IDLE_IN_FRAME: assert property (@(posedge clk) disable iff (rst || unf) in_frame_out |-> out_char != CH_IDLE); // R5
    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (rst) occ <= OCC_W'(FIFO_DEPTH)); // R8
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst) ovf |=> ovf); // R8
    AST_UNF_STICKY: assert property (@(posedge clk) disable iff (rst) unf |=> unf); // R9
    AST_CNT_SAT: assert property (@(posedge clk) disable iff (rst) frame_cnt <= CNT_W'(MAX_REGIONS)); // R10
endmodule

bind rx_idle_ins_buf iib_checker #(
    .FIFO_DEPTH  (FIFO_DEPTH),
    .MAX_REGIONS (REGIONS_PER_FRAME),
    .OCC_W       (OCC_W),
    .CNT_W       (CNT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .out_char  (out_char),
    .out_run   (out_run),
    .ovf       (ovf_flag),
    .unf       (unf_flag),
    .occ       (fifo_occ),
    .frame_cnt (frame_cnt)
);

// File: tb/tb_rx_idle_ins_buf.sv
module tb_rx_idle_ins_buf;
    localparam int CLK_PERIOD = 10;
    localparam int PREFILL    = 32;
    localparam int DEPTH      = 64;
    localparam int BPR        = 4;
    localparam int MAXR       = 8;
    localparam int PMAX       = 255;
    localparam logic [8:0] IDLE  = 9'h107;
    localparam logic [8:0] START = 9'h1FB;
    localparam logic [8:0] TERM  = 9'h1FD;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [8:0] in_char = IDLE;
    logic in_par_mark = 1'b0;
    logic [8:0] out_char;
    logic out_run, ovf_flag, unf_flag;

    rx_idle_ins_buf dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_char(in_char),
        .in_par_mark(in_par_mark), .out_char(out_char), .out_run(out_run),
        .ovf_flag(ovf_flag), .unf_flag(unf_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    string tag = "R3";

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // behavioural reference model
    typedef struct { logic [8:0] ch; int cnt; } ent_t;
    ent_t q[$];
    int wq[$];
    int m_pend = 0;
    bit m_run = 0;
    logic [8:0] m_out = IDLE;
    bit m_open = 0;
    int m_fcnt = 0;
    bit m_ovf = 0;
    bit m_unf = 0;

    always @(posedge clk) begin : model
        int occ;
        int add;
        int ci;
        int fm;
        ent_t e;
        if (rst) begin
            q.delete(); wq.delete();
            m_pend = 0; m_run = 0; m_out = IDLE; m_open = 0;
            m_fcnt = 0; m_ovf = 0; m_unf = 0;
        end else begin
            occ = q.size();
            add = 0;
            if (!m_run) begin
                if (occ >= PREFILL) m_run = 1;
                m_out = IDLE;
            end else if (m_pend > 0 && (m_out == IDLE || m_out == TERM)) begin
                m_out = IDLE;
                m_pend--;
            end else if (occ > 0) begin
                e = q.pop_front();
                m_out = e.ch;
                add += e.cnt * BPR;
            end else begin
                m_out = IDLE;
                m_unf = 1;
            end
            fm = (in_par_mark && m_open) ? 1 : 0;
            if (in_par_mark && !m_open) add += BPR;
            ci = m_fcnt + fm;
            if (ci > MAXR) ci = MAXR;
            if (in_valid) begin
                if (occ >= DEPTH) m_ovf = 1;
                else begin
                    e.ch = in_char;
                    e.cnt = (in_char == TERM && m_open) ? ci : 0;
                    q.push_back(e);
                    if (in_char == START) wq.push_back(cyc + 1);
                end
            end
            if (in_valid && in_char == START) begin
                m_open = 1; m_fcnt = 0;
            end else if (in_valid && in_char == TERM && m_open) begin
                m_open = 0; m_fcnt = 0;
            end else begin
                m_fcnt = ci;
            end
            m_pend += add;
            if (m_pend > PMAX) m_pend = PMAX;
        end
        cyc++;
    end

    // per-cycle comparison and output monitors
    bit lat_phase = 0;
    int first_lat = -1;
    int gap_before[16];
    int start_idx = 0;
    int idle_run = 0;
    bit after_term = 0;

    always @(negedge clk) begin
        chk(out_char == m_out, tag, "out_char", out_char, m_out);
        chk(out_run == m_run, "R2", "out_run", out_run, m_run);
        chk(ovf_flag == m_ovf, "R8", "ovf_flag", ovf_flag, m_ovf);
        chk(unf_flag == m_unf, "R9", "unf_flag", unf_flag, m_unf);
        if (rst) begin
            start_idx = 0; after_term = 0; idle_run = 0;
        end else if (out_run) begin
            if (out_char == START) begin
                if (wq.size() > 0) begin
                    int lat;
                    lat = cyc - wq.pop_front();
                    if (lat_phase) begin
                        if (first_lat < 0) first_lat = lat;
                        else chk(lat == first_lat, "R7", "START latency", lat, first_lat);
                    end
                end
                if (start_idx < 16) gap_before[start_idx] = after_term ? idle_run : -1;
                start_idx++;
                after_term = 0;
            end else if (out_char == TERM) begin
                after_term = 1; idle_run = 0;
            end else if (out_char == IDLE) begin
                idle_run++;
            end else begin
                after_term = 0;
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 20000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic drive(input logic v, input logic [8:0] c, input logic m);
        @(negedge clk);
        in_valid = v; in_char = c; in_par_mark = m;
    endtask

    task automatic idles(input int n);
        for (int i = 0; i < n; i++) drive(1'b1, IDLE, 1'b0);
    endtask

    task automatic gap();
        drive(1'b0, IDLE, 1'b1);
        for (int i = 0; i < 3; i++) drive(1'b0, IDLE, 1'b0);
    endtask

    task automatic frame(input int len, input int nmarks, input int spacing);
        int done;
        done = 0;
        drive(1'b1, START, 1'b0);
        for (int i = 0; i < len; i++) begin
            drive(1'b1, {1'b0, 8'(i)}, 1'b0);
            if (nmarks > 0 && ((i + 1) % spacing) == 0 && done < nmarks) begin
                gap();
                done++;
            end
        end
        drive(1'b1, TERM, 1'b0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) gap_before[i] = -2;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(out_char == IDLE && !out_run && !ovf_flag && !unf_flag, "R1", "reset outputs", out_char, IDLE);
        rst = 1'b0;
        // R2 prefill timing
        idles(32);
        @(negedge clk);
        chk(out_run == 1'b0, "R2", "run before prefill edge", out_run, 0);
        @(negedge clk);
        chk(out_run == 1'b1, "R2", "run after prefill edge", out_run, 1);
        idles(6);

        // R3/R4/R5/R7 frames of varied length and region placement
        lat_phase = 1;
        tag = "R4";
        frame(20, 0, 1);   idles(6);
        frame(60, 3, 15);
        frame(100, 8, 12); idles(10);
        frame(8, 1, 4);    idles(5);
        frame(30, 0, 1);   idles(40);
        repeat (10) @(negedge clk);
        lat_phase = 0;
        chk(first_lat > 0, "R7", "latency measured", first_lat, 1);
        chk(gap_before[1] == 6, "R4", "idles after zero-region frame", gap_before[1], 6);
        chk(gap_before[2] == 12, "R4", "idles after three-region frame", gap_before[2], 12);
        chk(gap_before[3] == 42, "R4", "idles after eight-region frame", gap_before[3], 42);
        chk(gap_before[4] == 9, "R5", "idles after one-region frame", gap_before[4], 9);

        // R6 deleted regions between frames
        tag = "R6";
        for (int k = 0; k < 20; k++) begin gap(); idles(2); end
        idles(40);
        chk(!unf_flag && !ovf_flag, "R6", "flags after idle-stretch regions", {ovf_flag, unf_flag}, 0);

        // R10 count saturation: nine markers in one frame
        tag = "R10";
        drive(1'b1, START, 1'b0);
        for (int j = 0; j < 9; j++) begin
            for (int i = 0; i < 4; i++) drive(1'b1, {1'b0, 8'(j * 4 + i)}, 1'b0);
            if (j < 5) gap();
            else drive(1'b1, {1'b0, 8'(200 + j)}, 1'b1);
        end
        drive(1'b1, TERM, 1'b0);
        frame(10, 0, 1);
        idles(40);
        repeat (10) @(negedge clk);
        chk(gap_before[6] == 32, "R10", "idles after saturated frame", gap_before[6], 32);

        // R8 overflow via markers with valid held high
        tag = "R8";
        for (int i = 0; i < 40; i++) drive(1'b1, IDLE, 1'b1);
        idles(2);
        chk(ovf_flag == 1'b1, "R8", "overflow set", ovf_flag, 1);
        idles(10);
        chk(ovf_flag == 1'b1, "R8", "overflow sticky", ovf_flag, 1);

        // R1 again, then R9 underflow
        tag = "R1";
        drive(1'b0, IDLE, 1'b0);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(out_char == IDLE && !out_run && !ovf_flag && !unf_flag, "R1", "outputs after second reset", {ovf_flag, unf_flag, out_run}, 0);
        tag = "R9";
        idles(40);
        for (int i = 0; i < 50; i++) drive(1'b0, IDLE, 1'b0);
        chk(unf_flag == 1'b1, "R9", "underflow set", unf_flag, 1);
        chk(out_char == IDLE, "R9", "starved output", out_char, IDLE);
        idles(10);
        chk(unf_flag == 1'b1, "R9", "underflow sticky", unf_flag, 1);

        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule